// File: doc/BRIEF.md
# I2C Indexed Register-Access Slave

This block is an I2C-bus slave that gives a host controller access to a small internal memory map. Every write message carries an index byte straight after the slave address. That byte selects the target element, and any further bytes in the message are stored there. A read message has no address of its own. It returns data starting at whatever index the last write left behind. The combined format is supported: a write sets the index, then a repeated START turns the bus around for a read.

Control registers are reached directly through the index. A byte-wide RAM sits behind two pointer registers (row and column) and one data port register. Each data access steps the index for ordinary registers. For the RAM port it steps the RAM pointer instead, and the column carries into the row. Event inputs set sticky status flags. A level interrupt output tells the host that an enabled flag is waiting, so the host does not have to poll.

The engine is a single state machine clocked by the system clock. It follows synchronised SCL and SDA and drives SDA low only through an open-drain enable. Its states are IDLE (bus free or released), ADDR (shifting in the address byte), ADDR_ACK (driving the address acknowledge), WR_BYTE (shifting in a write byte), WR_ACK (driving the write acknowledge), RD_BYTE (shifting out a read byte), RD_ACK (sampling the master's acknowledge) and IGNORE (not addressed or read ended; waiting for START or STOP). Its transitions are:
- START to ADDR from any state.
- STOP to IDLE from any state.
- ADDR to ADDR_ACK on an address match, or to IGNORE on a mismatch.
- ADDR_ACK to RD_BYTE or WR_BYTE, chosen by the R/W bit.
- WR_BYTE to WR_ACK, and back again.
- RD_BYTE to RD_ACK.
- RD_ACK to RD_BYTE on ACK, or to IGNORE on NACK.

Top module: `i2c_idx_slave`

## Requirements
- R1: The first byte after START is a 7-bit address (MSB first) followed by R/W (0 write, 1 read). The slave pulls SDA low in the ninth clock only when the address equals DEV_ADDR (default 0x2C). Otherwise it leaves SDA released until the next START.
- R2: In a write message the byte after the address is loaded into the index. Each following byte is stored in the element the index selects, and every byte is acknowledged.
- R3: A read message starts returning data at the current index, with no index byte. This holds both after a STOP and after a repeated START that follows a write (the combined format).
- R4: After each data byte written or read at any index other than 0x06, the index increments by one, wrapping from 0xFF to 0x00.
- R5: Index 0x04 holds the RAM row and index 0x05 the RAM column (low bits, zero-extended on read). Index 0x06 reads or writes the RAM at {row,col}. An access at 0x06 leaves the index unchanged and increments {row,col} as one counter, so the column wraps into the next row and the last location wraps to row 0, column 0.
- R6: Index 0x03 always reads 0xA5 and index 0x02 returns the status flags. Writes to either have no effect.
- R7: When the master answers a read byte with NACK, the slave releases SDA and sends no further data until the next START.
- R8: A high pulse on evt_i[n] sets status flag n. irq is high while any flag is set whose bit in the enable register (index 0x01) is 1. A read of index 0x02 clears exactly the flags it returned.
- R9: A START or STOP inside a byte abandons that byte without storing it. The index keeps its value.
- R10: Indices 0x07 to 0xFF read as 0x00. After reset, irq is low, SDA is released and all registers hold 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | When high, SDA is pulled low (open drain) |
| evt_i | input | EVT_W | Event pulses, one per status flag |
| irq | output | 1 | Level interrupt to the host |

## Verification
The hardest situation to reach from the ports is a bus condition that lands in the middle of a byte. The engine is then partly through its shift register, and the index already holds a value loaded earlier in the same message. The bench gets there by bit-banging: it clocks only a few data bits, then raises SDA with SCL low and makes either a repeated START or a STOP. A later read shows that the index survived and that the partial byte was never stored. Pointer carry across the row boundary and wrap at the last location are reached by loading the pointer next to each edge and streaming through it.

// File: rtl/i2c_idx_pkg.sv
package i2c_idx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_IGNORE
    } eng_state_t;

    // index map; RAM_IO is the only index that must not auto-increment
    localparam logic [7:0] IDX_CTRL    = 8'h00;
    localparam logic [7:0] IDX_IRQ_EN  = 8'h01;
    localparam logic [7:0] IDX_STATUS  = 8'h02;
    localparam logic [7:0] IDX_ID      = 8'h03;
    localparam logic [7:0] IDX_PTR_ROW = 8'h04;
    localparam logic [7:0] IDX_PTR_COL = 8'h05;
    localparam logic [7:0] IDX_RAM_IO  = 8'h06;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] synced;
    logic [LINES-1:0] prev;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= '1;
        else        prev <= synced;
    end

    assign scl_s     = synced[1];
    assign sda_s     = synced[0];
    assign scl_rise  =  synced[1] & ~prev[1];
    assign scl_fall  = ~synced[1] &  prev[1];
    assign start_det =  synced[1] &  prev[1] &  prev[0] & ~synced[0];
    assign stop_det  =  synced[1] &  prev[1] & ~prev[0] &  synced[0];

endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
    import i2c_idx_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h2C
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_s,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [7:0] rd_data,
    output logic       sda_oe,
    output logic       idx_wr,
    output logic       dat_wr,
    output logic [7:0] wr_byte,
    output logic       rd_req
);
    localparam int BITS = 8;
    localparam int CW   = $clog2(BITS + 1);

    eng_state_t    state, state_nx;
    logic [CW-1:0] bitcnt;
    logic [7:0]    rx_sh;
    logic [7:0]    tx_sh;
    logic          rw_q;
    logic          idx_phase;
    logic          m_ack;
    logic          got8;
    logic          quiet;
    logic          addr_hit;

    assign got8     = (bitcnt == CW'(BITS));
    assign quiet    = !start_det && !stop_det;
    assign addr_hit = (rx_sh[7:1] == DEV_ADDR);
    assign wr_byte  = rx_sh;

    // next-state logic
    always_comb begin
        state_nx = state;
        if (start_det) begin
            state_nx = ST_ADDR;
        end else if (stop_det) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     state_nx = ST_IDLE;
                ST_ADDR:     if (scl_fall && got8) state_nx = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall) state_nx = rw_q ? ST_RD_BYTE : ST_WR_BYTE;
                ST_WR_BYTE:  if (scl_fall && got8) state_nx = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall) state_nx = ST_WR_BYTE;
                ST_RD_BYTE:  if (scl_fall && bitcnt == CW'(BITS - 1)) state_nx = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall) state_nx = m_ack ? ST_RD_BYTE : ST_IGNORE;
                ST_IGNORE:   state_nx = ST_IGNORE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // shift registers and per-message flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt    <= '0;
            rx_sh     <= '0;
            tx_sh     <= '1;
            rw_q      <= 1'b0;
            idx_phase <= 1'b0;
            m_ack     <= 1'b0;
        end else if (!quiet) begin
            bitcnt <= '0;
        end else begin
            case (state)
                ST_ADDR, ST_WR_BYTE: begin
                    if (scl_rise && !got8) begin
                        rx_sh  <= {rx_sh[6:0], sda_s};
                        bitcnt <= bitcnt + 1'b1;
                    end
                    if (scl_fall && got8) begin
                        bitcnt <= '0;
                        if (state == ST_ADDR) rw_q <= rx_sh[0];
                        else                  idx_phase <= 1'b0;
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        bitcnt <= '0;
                        if (rw_q) tx_sh <= rd_data;
                        else      idx_phase <= 1'b1;
                    end
                end
                ST_RD_BYTE: begin
                    if (scl_fall) begin
                        tx_sh  <= {tx_sh[6:0], 1'b1};
                        bitcnt <= (bitcnt == CW'(BITS - 1)) ? '0 : bitcnt + 1'b1;
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) m_ack <= !sda_s;
                    if (scl_fall && m_ack) tx_sh <= rd_data;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_oe = 1'b0;
        idx_wr = 1'b0;
        dat_wr = 1'b0;
        rd_req = 1'b0;
        unique case (state)
            ST_ADDR_ACK: begin
                sda_oe = 1'b1;
                rd_req = scl_fall && rw_q && quiet;
            end
            ST_WR_ACK:  sda_oe = 1'b1;
            ST_RD_BYTE: sda_oe = !tx_sh[7];
            ST_WR_BYTE: begin
                idx_wr = scl_fall && got8 && quiet &&  idx_phase;
                dat_wr = scl_fall && got8 && quiet && !idx_phase;
            end
            ST_RD_ACK:  rd_req = scl_fall && m_ack && quiet;
            ST_IDLE, ST_ADDR, ST_IGNORE: ;
        endcase
    end

    // R1: the slave only starts pulling SDA while SCL is low
    p_oe_rise_scl_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    // R2: at most one register-side strobe per cycle
    p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({idx_wr, dat_wr, rd_req}));

    // R7: a NACK from the master leaves SDA released
    p_nack_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_ACK && scl_fall && !m_ack && quiet) |=> !sda_oe);

    // R9: any START rearms the address phase from bit zero
    p_start_rearm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_ADDR && bitcnt == '0));

endmodule

// File: rtl/i2c_regmap.sv
module i2c_regmap
    import i2c_idx_pkg::*;
#(
    parameter int         ROW_W    = 3,
    parameter int         COL_W    = 3,
    parameter int         EVT_W    = 8,
    parameter logic [7:0] ID_VALUE = 8'hA5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idx_wr,
    input  logic             dat_wr,
    input  logic [7:0]       wr_byte,
    input  logic             rd_req,
    input  logic [EVT_W-1:0] evt_i,
    output logic [7:0]       rd_data,
    output logic [7:0]       index_o,
    output logic             irq
);
    localparam int AW    = ROW_W + COL_W;
    localparam int DEPTH = 1 << AW;

    logic [7:0]       index;
    logic [7:0]       ctrl;
    logic [EVT_W-1:0] irq_en;
    logic [EVT_W-1:0] flags;
    logic [EVT_W-1:0] clr_mask;
    logic [AW-1:0]    ptr;
    logic [7:0]       mem [DEPTH];
    logic             at_ram;
    logic             access;

    assign at_ram  = (index == IDX_RAM_IO);
    assign access  = dat_wr || rd_req;
    assign index_o = index;

    always_comb begin
        case (index)
            IDX_CTRL:    rd_data = ctrl;
            IDX_IRQ_EN:  rd_data = 8'(irq_en);
            IDX_STATUS:  rd_data = 8'(flags);
            IDX_ID:      rd_data = ID_VALUE;
            IDX_PTR_ROW: rd_data = 8'(ptr[AW-1 -: ROW_W]);
            IDX_PTR_COL: rd_data = 8'(ptr[COL_W-1:0]);
            IDX_RAM_IO:  rd_data = mem[ptr];
            default:     rd_data = 8'h00;
        endcase
    end

    assign clr_mask = (rd_req && index == IDX_STATUS) ? flags : '0;

    // index: load from the index byte, step after register accesses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  index <= '0;
        else if (idx_wr)             index <= wr_byte;
        else if (access && !at_ram)  index <= index + 1'b1;
    end

    // directly mapped registers and the RAM pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl   <= '0;
            irq_en <= '0;
            ptr    <= '0;
        end else begin
            if (dat_wr) begin
                case (index)
                    IDX_CTRL:    ctrl   <= wr_byte;
                    IDX_IRQ_EN:  irq_en <= wr_byte[EVT_W-1:0];
                    IDX_PTR_ROW: ptr[AW-1 -: ROW_W] <= wr_byte[ROW_W-1:0];
                    IDX_PTR_COL: ptr[COL_W-1:0]     <= wr_byte[COL_W-1:0];
                    default: ;
                endcase
            end
            if (access && at_ram) ptr <= ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (dat_wr && at_ram) mem[ptr] <= wr_byte;
    end

    // sticky flags: a new event wins over a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr_mask) | evt_i;
    end

    assign irq = |(flags & irq_en);

    // R8: a flag only drops after the status register was read
    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(flags) & ~flags)) |-> $past(rd_req && index == IDX_STATUS));

    // R5: a RAM port access leaves the index on the port
    p_idx_hold_ram_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (access && at_ram) |=> (index == IDX_RAM_IO));

    // R5: a RAM port access moves the pointer by exactly one location
    p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (access && at_ram) |=> (ptr == AW'($past(ptr) + 1'b1)));

endmodule

// File: rtl/i2c_idx_slave.sv
module i2c_idx_slave #(
    parameter logic [6:0] DEV_ADDR    = 7'h2C,
    parameter int         ROW_W       = 3,
    parameter int         COL_W       = 3,
    parameter int         EVT_W       = 8,
    parameter logic [7:0] ID_VALUE    = 8'hA5,
    parameter int         SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    input  logic [EVT_W-1:0] evt_i,
    output logic             irq
);
    logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic       idx_wr, dat_wr, rd_req;
    logic [7:0] wr_byte, rd_data, index;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_bit_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .sda_oe    (sda_oe),
        .idx_wr    (idx_wr),
        .dat_wr    (dat_wr),
        .wr_byte   (wr_byte),
        .rd_req    (rd_req)
    );

    i2c_regmap #(
        .ROW_W    (ROW_W),
        .COL_W    (COL_W),
        .EVT_W    (EVT_W),
        .ID_VALUE (ID_VALUE)
    ) u_regmap (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx_wr  (idx_wr),
        .dat_wr  (dat_wr),
        .wr_byte (wr_byte),
        .rd_req  (rd_req),
        .evt_i   (evt_i),
        .rd_data (rd_data),
        .index_o (index),
        .irq     (irq)
    );

    // R9: a bus condition never disturbs the index
    p_idx_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det || stop_det) |=> $stable(index));

endmodule

// File: tb/i2c_idx_slave_bench.sv
module i2c_idx_slave_bench;
    localparam int         QP   = 10;
    localparam logic [6:0] ADDR = 7'h2C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [7:0] evt = '0;
    logic       sda_oe, irq, sda_line;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    i2c_idx_slave u_i2c_idx_slave (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl_m),
        .sda_i  (sda_line),
        .sda_oe (sda_oe),
        .evt_i  (evt),
        .irq    (irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(QP); scl_m = 1'b1; wq(QP);
        sda_m = 1'b0; wq(QP); scl_m = 1'b0; wq(QP);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(QP); scl_m = 1'b1; wq(QP);
        sda_m = 1'b1; wq(2*QP);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wq(QP); scl_m = 1'b1; wq(2*QP); scl_m = 1'b0; wq(QP);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; wq(QP); scl_m = 1'b1; wq(QP);
        ack = ~sda_line;
        wq(QP); scl_m = 1'b0; wq(QP);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(QP); scl_m = 1'b1; wq(QP);
            b[i] = sda_line;
            wq(QP); scl_m = 1'b0; wq(QP);
        end
        sda_m = ~give_ack; wq(QP); scl_m = 1'b1; wq(2*QP); scl_m = 1'b0; wq(QP);
        sda_m = 1'b1;
    endtask

    // write: address, index byte, n data bytes; optional STOP
    task automatic write_seq(input logic [7:0] idx, input logic [7:0] d [4], input int n, input bit stop);
        logic ack;
        bus_start();
        send_byte({ADDR, 1'b0}, ack); chk("R1 write address ACK", 8'(ack), 8'h01);
        send_byte(idx, ack);          chk("R2 index byte ACK", 8'(ack), 8'h01);
        for (int i = 0; i < n; i++) begin
            send_byte(d[i], ack);     chk("R2 data byte ACK", 8'(ack), 8'h01);
        end
        if (stop) bus_stop();
    endtask

    // read: (repeated) START, address, n bytes with NACK on the last, STOP
    task automatic read_seq(input int n, output logic [7:0] d [4]);
        logic ack;
        bus_start();
        send_byte({ADDR, 1'b1}, ack); chk("R1 read address ACK", 8'(ack), 8'h01);
        for (int i = 0; i < n; i++) recv_byte(i != n - 1, d[i]);
        bus_stop();
    endtask

    task automatic t_reset();
        logic [7:0] d [4];
        chk("R10 reset irq", 8'(irq), 8'h00);
        chk("R10 reset sda released", 8'(sda_oe), 8'h00);
        write_seq(8'h00, d, 0, 1'b0);
        read_seq(2, d);
        chk("R10 reset ctrl", d[0], 8'h00);
        chk("R10 reset enable", d[1], 8'h00);
    endtask

    task automatic t_addr_miss();
        logic ack;
        bus_start();
        send_byte({7'h13, 1'b0}, ack);
        chk("R1 foreign address not acked", 8'(ack), 8'h00);
        send_byte(8'h00, ack);
        chk("R1 ignored after foreign address", 8'(ack), 8'h00);
        bus_stop();
    endtask

    task automatic t_regs();
        logic [7:0] d [4] = '{8'h11, 8'h22, 8'h00, 8'h00};
        logic [7:0] r [4];
        write_seq(8'h00, d, 2, 1'b1);
        write_seq(8'h00, d, 0, 1'b0);
        read_seq(2, r);
        chk("R2 ctrl written", r[0], 8'h11);
        chk("R4 index stepped to enable", r[1], 8'h22);
    endtask

    task automatic t_read_last();
        logic [7:0] d [4] = '{8'h77, 8'h00, 8'h00, 8'h00};
        logic [7:0] r [4];
        write_seq(8'h00, d, 1, 1'b1);
        write_seq(8'h00, d, 0, 1'b1);
        read_seq(1, r);
        chk("R3 read after STOP uses last index", r[0], 8'h77);
    endtask

    task automatic t_ro();
        logic [7:0] d [4] = '{8'h00, 8'hFF, 8'h00, 8'h00};
        logic [7:0] r [4];
        write_seq(8'h03, d, 1, 1'b1);
        write_seq(8'h02, d, 2, 1'b1);
        write_seq(8'h02, d, 0, 1'b0);
        read_seq(2, r);
        chk("R6 status unchanged by write", r[0], 8'h00);
        chk("R6 id unchanged by write", r[1], 8'hA5);
        write_seq(8'h07, d, 0, 1'b0);
        read_seq(2, r);
        chk("R10 unmapped 0x07", r[0], 8'h00);
        chk("R10 unmapped 0x08", r[1], 8'h00);
        write_seq(8'hFF, d, 0, 1'b0);
        read_seq(2, r);
        chk("R10 unmapped 0xFF", r[0], 8'h00);
        chk("R4 index wraps to 0x00", r[1], 8'h77);
    endtask

    task automatic t_ram();
        logic [7:0] d [4] = '{8'h00, 8'h06, 8'hA1, 8'hA2};
        logic [7:0] e [4] = '{8'hA3, 8'h00, 8'h00, 8'h00};
        logic [7:0] r [4];
        write_seq(8'h04, d, 4, 1'b0);
        send_byte(e[0], r[0][0]);
        chk("R5 third RAM byte ACK", 8'(r[0][0]), 8'h01);
        bus_stop();
        write_seq(8'h04, d, 2, 1'b0);
        read_seq(3, r);
        chk("R5 RAM row0 col6", r[0], 8'hA1);
        chk("R5 RAM row0 col7", r[1], 8'hA2);
        chk("R5 RAM carry to row1 col0", r[2], 8'hA3);
        write_seq(8'h04, d, 0, 1'b0);
        read_seq(2, r);
        chk("R5 pointer row after stream", r[0], 8'h01);
        chk("R5 pointer col after stream", r[1], 8'h01);
    endtask

    task automatic t_ram_wrap();
        logic [7:0] d [4] = '{8'h07, 8'h07, 8'h5A, 8'h00};
        logic [7:0] r [4];
        write_seq(8'h04, d, 3, 1'b1);
        write_seq(8'h04, d, 0, 1'b0);
        read_seq(2, r);
        chk("R5 pointer wraps to row 0", r[0], 8'h00);
        chk("R5 pointer wraps to col 0", r[1], 8'h00);
        write_seq(8'h04, d, 2, 1'b0);
        read_seq(1, r);
        chk("R5 last RAM location stored", r[0], 8'h5A);
    endtask

    task automatic t_nack();
        logic [7:0] d [4];
        logic [7:0] r;
        logic       ack;
        write_seq(8'h03, d, 0, 1'b0);
        bus_start();
        send_byte({ADDR, 1'b1}, ack);
        recv_byte(1'b0, r);
        chk("R7 byte before NACK", r, 8'hA5);
        recv_byte(1'b0, r);
        chk("R7 SDA released after NACK", r, 8'hFF);
        bus_stop();
    endtask

    task automatic t_irq();
        logic [7:0] d [4] = '{8'h05, 8'h00, 8'h00, 8'h00};
        logic [7:0] r [4];
        write_seq(8'h01, d, 1, 1'b1);
        evt = 8'h02; wq(1); evt = 8'h00; wq(3);
        chk("R8 masked flag keeps irq low", 8'(irq), 8'h00);
        evt = 8'h01; wq(1); evt = 8'h00; wq(3);
        chk("R8 enabled flag raises irq", 8'(irq), 8'h01);
        write_seq(8'h02, d, 0, 1'b0);
        read_seq(1, r);
        chk("R8 status value", r[0], 8'h03);
        chk("R8 irq cleared by status read", 8'(irq), 8'h00);
        write_seq(8'h02, d, 0, 1'b0);
        read_seq(1, r);
        chk("R8 flags cleared", r[0], 8'h00);
    endtask

    task automatic t_abort();
        logic [7:0] d [4] = '{8'h3C, 8'h00, 8'h00, 8'h00};
        logic [7:0] r [4];
        logic       ack;
        write_seq(8'h00, d, 1, 1'b1);
        bus_start();
        send_byte({ADDR, 1'b0}, ack);
        send_byte(8'h00, ack);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        read_seq(1, r);
        chk("R9 restart mid-byte keeps index, no store", r[0], 8'h3C);
        bus_start();
        send_byte({ADDR, 1'b0}, ack);
        send_byte(8'h00, ack);
        for (int i = 0; i < 3; i++) send_bit(1'b1);
        bus_stop();
        read_seq(1, r);
        chk("R9 STOP mid-byte keeps index, no store", r[0], 8'h3C);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        wq(5);
        rst_n = 1'b1;
        wq(5);
        t_reset();
        t_addr_miss();
        t_regs();
        t_read_last();
        t_ro();
        t_ram();
        t_ram_wrap();
        t_nack();
        t_irq();
        t_abort();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule